// File: doc/BRIEF.md
# Multi-Mode Parallel Host Bus Slave

This block lets an external 8-bit host read and write a bank of 64 byte-wide internal registers through one shared set of pins. The same pins carry five host bus styles. Two styles use a separate 3-bit address bus: one has separate active-low read and write strobes, the other has one active-low data strobe and a read/not-write line. Two styles carry a 6-bit address on the data lines, captured by a high-active address latch pulse. The fifth is a PC enhanced-parallel-port handshake with address and data strobes, an active-low write line and a wait output.

After every reset the block reads the levels of the control and address pins and picks the bus style from them. It keeps that style until the next reset. Every host control, address and data input passes through a two-stage synchronizer, and all strobe edges are found in the block's own clock domain. On the inside the block drives a simple register-file port: one address, a write pulse with its data, and a read enable with combinational read data. The read data goes back to the host together with an output-enable that stands in for the tri-state bus driver.

Top module: `hostbus_slave`

## Requirements
- R1: After reset is released, mode_o reads 7 for the first two clock edges. From the third edge on, mode_o holds the style decoded from the synchronized pins, checked in this order: hb_cs_n low with hb_astb high gives 4 (handshake). Otherwise hb_addr equal to 3'b111 gives 2 if hb_dir is high and 3 if it is low (multiplexed). Otherwise the code is 0 if hb_dir is high and 1 if it is low (separate address). While reset is held low, mode_o is 7 and hb_d_oe and hb_wait are 0.
- R2: Once mode_o has left 7 it does not change until the next reset, whatever the pins do.
- R3: Mode 0: a rising hb_stb (the write strobe) while hb_cs_n is low writes the data held during the low phase to register {page, hb_addr}. While hb_cs_n and hb_dir (the read strobe) are both low, the block drives that register's value.
- R4: In modes 0 and 1, host address 0 selects a 3-bit page register. Writing it loads data bits [2:0] and does not write the register file. Reading it returns the page in bits [2:0] with zeros above. The page register resets to 0.
- R5: Mode 1: hb_stb is the data strobe and hb_dir is read/not-write. A write happens on a rising data strobe with hb_cs_n low and hb_dir low. A read is driven while hb_cs_n and the data strobe are low and hb_dir is high.
- R6: Modes 2 and 3: while hb_astb is high, the address is taken from hb_d_in[5:0], and the hb_addr pins are ignored. Mode 2 then uses the strobes of R3 and mode 3 the strobes of R5 on that 6-bit address.
- R7: Mode 4: an address cycle has hb_astb low. With hb_dir low it loads hb_d_in[5:0] into the address register when hb_astb rises. With hb_dir high it drives the address register, zero-extended.
- R8: Mode 4: a data cycle has hb_stb low. With hb_dir low it writes the register at the stored address when hb_stb rises. With hb_dir high it drives that register's value. hb_cs_n has no effect.
- R9: In mode 4, hb_wait goes high within three clocks of either strobe falling and low within three clocks of both strobes being high again. In every other mode it stays low.
- R10: hb_d_oe is high only during a selected read cycle. With hb_cs_n high in modes 0 to 3, strobes neither drive the bus nor write.
- R11: Each host write produces exactly one single-cycle rf_we pulse, and none for a page-register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the detected style |
| hb_cs_n | input | 1 | Active-low chip select (tied low for the handshake style) |
| hb_dir | input | 1 | Read strobe (modes 0, 2), read/not-write (modes 1, 3), active-low write line (mode 4) |
| hb_stb | input | 1 | Write strobe (modes 0, 2) or data strobe (modes 1, 3, 4), active low |
| hb_astb | input | 1 | Address latch, high-active (modes 2, 3); address strobe, active low (mode 4) |
| hb_addr | input | 3 | Separate address pins (modes 0, 1) |
| hb_d_in | input | 8 | Host data / multiplexed address in |
| hb_d_out | output | 8 | Read data toward the host |
| hb_d_oe | output | 1 | Drive enable for hb_d_out |
| hb_wait | output | 1 | Handshake wait output (mode 4) |
| mode_o | output | 3 | Detected bus style, 7 while undetected |
| rf_addr | output | 6 | Register file address |
| rf_we | output | 1 | Register file write pulse |
| rf_wdata | output | 8 | Register file write data |
| rf_re | output | 1 | Register file read enable |
| rf_rdata | input | 8 | Register file read data |

## Verification
The hardest condition to reach is the detection window. The straps are read only on the third edge after reset, and after that they must be ignored. The bench resets the block once per bus style with the matching strap levels. It then changes the strap pins on purpose (the direction line and the address pins) while it checks the style code on every clock. The page register reached through address 0, and the address register of the handshake style, are exercised by write-then-read sequences whose results depend on the stored page or address.

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int DW  = 8,
  parameter int AW  = 6,
  parameter int SAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hb_cs_n,
  input  logic           hb_dir,
  input  logic           hb_stb,
  input  logic           hb_astb,
  input  logic [SAW-1:0] hb_addr,
  input  logic [DW-1:0]  hb_d_in,
  output logic [DW-1:0]  hb_d_out,
  output logic           hb_d_oe,
  output logic           hb_wait,
  output logic [2:0]     mode_o,
  output logic [AW-1:0]  rf_addr,
  output logic           rf_we,
  output logic [DW-1:0]  rf_wdata,
  output logic           rf_re,
  input  logic [DW-1:0]  rf_rdata
);
  localparam int PW = AW - SAW;
  localparam int IW = 4 + SAW + DW;
  localparam logic [2:0] M_SEP2 = 3'd0, M_SEP1 = 3'd1, M_MUX2 = 3'd2,
                         M_MUX1 = 3'd3, M_EPP = 3'd4, M_NONE = 3'd7;

  logic [IW-1:0]  sy1, sy2;
  logic           s_cs, s_dir, s_stb, s_astb;
  logic [SAW-1:0] s_a;
  logic [DW-1:0]  s_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
    end else begin
      sy1 <= {hb_cs_n, hb_dir, hb_stb, hb_astb, hb_addr, hb_d_in};
      sy2 <= sy1;
    end

  assign {s_cs, s_dir, s_stb, s_astb, s_a, s_d} = sy2;

  logic q_stb, q_astb;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_stb  <= 1'b1;
      q_astb <= 1'b1;
    end else begin
      q_stb  <= s_stb;
      q_astb <= s_astb;
    end

  wire stb_rise  = s_stb & ~q_stb;
  wire astb_rise = s_astb & ~q_astb;

  logic [1:0] dcnt;
  logic [2:0] det;
  always_comb begin
    if (!s_cs && s_astb)  det = M_EPP;
    else if (&s_a)        det = s_dir ? M_MUX2 : M_MUX1;
    else                  det = s_dir ? M_SEP2 : M_SEP1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_o <= M_NONE;
      dcnt   <= '0;
    end else if (mode_o == M_NONE) begin
      if (dcnt == 2'd2) mode_o <= det;
      else              dcnt   <= dcnt + 2'd1;
    end

  wire is_sep = (mode_o == M_SEP2) || (mode_o == M_SEP1);
  wire is_mux = (mode_o == M_MUX2) || (mode_o == M_MUX1);
  wire is_epp = (mode_o == M_EPP);

  logic [PW-1:0] page;
  logic [AW-1:0] areg;
  logic [DW-1:0] wdat;
  logic          wr_go, rd_act;

  always_comb begin
    wr_go  = 1'b0;
    rd_act = 1'b0;
    case (mode_o)
      M_SEP2, M_MUX2: begin
        wr_go  = stb_rise & ~s_cs;
        rd_act = ~s_cs & ~s_dir;
      end
      M_SEP1, M_MUX1: begin
        wr_go  = stb_rise & ~s_cs & ~s_dir;
        rd_act = ~s_cs & ~s_stb & s_dir;
      end
      M_EPP: begin
        wr_go  = stb_rise & ~s_dir;
        rd_act = s_dir & (~s_stb | ~s_astb);
      end
      default: ;
    endcase
  end

  wire page_hit = is_sep && (s_a == '0);
  wire addr_rd  = is_epp && !s_astb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wdat <= '0;
      page <= '0;
      areg <= '0;
    end else begin
      if (!s_stb || (is_epp && !s_astb)) wdat <= s_d;
      if (wr_go && page_hit)             page <= wdat[PW-1:0];
      if (is_mux && s_astb)              areg <= s_d[AW-1:0];
      if (is_epp && astb_rise && !s_dir) areg <= wdat[AW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hb_wait <= 1'b0;
    else        hb_wait <= is_epp & (~s_stb | ~s_astb);

  assign rf_addr  = is_sep ? {page, s_a} : areg;
  assign rf_we    = wr_go & ~page_hit;
  assign rf_wdata = wdat;
  assign rf_re    = rd_act & ~page_hit & ~addr_rd;
  assign hb_d_oe  = rd_act;
  assign hb_d_out = !rd_act  ? '0 :
                    page_hit ? {{(DW-PW){1'b0}}, page} :
                    addr_rd  ? {{(DW-AW){1'b0}}, areg} : rf_rdata;
endmodule

module hostbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       hb_d_oe,
  input logic       hb_wait,
  input logic       rf_we,
  input logic       rf_re
);
  // R1
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o <= 3'd4) || (mode_o == 3'd7));
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 3'd7) |=> (mode_o == $past(mode_o)));
  // R9
  wait_epp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_wait |-> (mode_o == 3'd4));
  // R10
  oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hb_d_oe |-> (mode_o != 3'd7));
  // R10
  re_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |-> hb_d_oe);
  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
endmodule

bind hostbus_slave hostbus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .hb_d_oe(hb_d_oe),
  .hb_wait(hb_wait), .rf_we(rf_we), .rf_re(rf_re)
);

// File: tb/sim_hostbus_slave.sv
module sim_hostbus_slave;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, dir = 1'b1, stb = 1'b1, astb = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] din = 8'd0;
  logic [7:0] dout, rfwd, rfrd;
  logic oe, wt, rfwe, rfre;
  logic [2:0] mode;
  logic [5:0] rfa;

  logic [7:0] rfm [64];
  logic [7:0] mm  [64];
  logic [2:0] pg_m = 3'd0;
  logic [5:0] ea_m = 6'd0;
  logic [2:0] exp_mode = 3'd7;
  int cm = 0;
  integer ntot = 0, nbad = 0, edges = 0, we_cnt = 0;
  logic wr_ok = 1'b0, done = 1'b0;

  assign rfrd = rfm[rfa];

  hostbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_dir(dir), .hb_stb(stb),
    .hb_astb(astb), .hb_addr(addr), .hb_d_in(din), .hb_d_out(dout),
    .hb_d_oe(oe), .hb_wait(wt), .mode_o(mode), .rf_addr(rfa), .rf_we(rfwe),
    .rf_wdata(rfwd), .rf_re(rfre), .rf_rdata(rfrd)
  );

  always @(posedge clk) begin
    if (rfwe) begin
      rfm[rfa] <= rfwd;
      we_cnt   <= we_cnt + 1;
    end
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    ntot++;
    if (a !== e) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done) begin
      int mism;
      chk("R1 R2 mode per clock", mode, (rst_n && edges >= 3) ? exp_mode : 3'd7);
      chk("R10 stray write", rfwe && !wr_ok, 0);
      if (!wr_ok) begin
        mism = 0;
        for (int i = 0; i < 64; i++) if (rfm[i] !== mm[i]) mism++;
        chk("R11 register image", mism, 0);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rst_to(input logic c, input logic d, input logic as,
                        input logic [2:0] ad, input logic [2:0] em);
    rst_n = 1'b0; cs_n = c; dir = d; stb = 1'b1; astb = as; addr = ad;
    exp_mode = em; cm = em; pg_m = 3'd0; ea_m = 6'd0;
    cyc(3);
    chk("R1 reset mode", mode, 3'd7);
    chk("R1 reset oe", oe, 1'b0);
    chk("R1 reset wait", wt, 1'b0);
    rst_n = 1'b1;
    cyc(6);
  endtask

  task automatic wr_cycle(input logic [7:0] d, input logic pagew, input logic [5:0] fa);
    int w0;
    w0 = we_cnt; wr_ok = 1'b1; din = d; cs_n = 1'b0;
    if (cm == 1 || cm == 3) dir = 1'b0;
    cyc(1); stb = 1'b0; cyc(4); stb = 1'b1; cyc(4);
    cs_n = 1'b1; dir = 1'b1; cyc(1);
    if (pagew) pg_m = d[2:0]; else mm[fa] = d;
    chk("R11 write pulse count", we_cnt - w0, pagew ? 0 : 1);
    wr_ok = 1'b0;
  endtask

  task automatic rd_cycle(input string r, input logic [7:0] e);
    cs_n = 1'b0;
    if (cm == 0 || cm == 2) dir = 1'b0;
    else begin dir = 1'b1; stb = 1'b0; end
    cyc(4);
    chk(r, dout, e);
    chk("R10 oe during read", oe, 1'b1);
    dir = 1'b1; stb = 1'b1; cs_n = 1'b1;
    cyc(4);
    chk("R10 oe after read", oe, 1'b0);
  endtask

  task automatic sep_w(input logic [2:0] a, input logic [7:0] d);
    addr = a;
    wr_cycle(d, a == 3'd0, {pg_m, a});
  endtask

  task automatic sep_r(input string r, input logic [2:0] a);
    addr = a;
    rd_cycle(r, a == 3'd0 ? {5'd0, pg_m} : mm[{pg_m, a}]);
  endtask

  task automatic mux_al(input logic [5:0] fa);
    din = {2'b00, fa}; addr = 3'b101; astb = 1'b1; cyc(4); astb = 1'b0; cyc(1);
  endtask

  task automatic mux_w(input logic [5:0] fa, input logic [7:0] d);
    mux_al(fa);
    wr_cycle(d, 1'b0, fa);
  endtask

  task automatic mux_r(input string r, input logic [5:0] fa);
    mux_al(fa);
    rd_cycle(r, mm[fa]);
  endtask

  task automatic e_w(input logic isa, input logic [7:0] d);
    int w0;
    w0 = we_cnt; wr_ok = 1'b1; dir = 1'b0; din = d; cyc(1);
    if (isa) astb = 1'b0; else stb = 1'b0;
    cyc(4);
    chk("R9 wait high in write", wt, 1'b1);
    astb = 1'b1; stb = 1'b1; cyc(4);
    chk("R9 wait low after write", wt, 1'b0);
    dir = 1'b1; cyc(1);
    if (isa) ea_m = d[5:0]; else mm[ea_m] = d;
    chk(isa ? "R7 addr write no pulse" : "R8 data write pulse", we_cnt - w0, isa ? 0 : 1);
    wr_ok = 1'b0;
  endtask

  task automatic e_r(input logic isa);
    dir = 1'b1;
    if (isa) astb = 1'b0; else stb = 1'b0;
    cyc(4);
    chk(isa ? "R7 addr read" : "R8 data read", dout, isa ? {2'b00, ea_m} : mm[ea_m]);
    chk("R9 wait high in read", wt, 1'b1);
    chk("R10 oe in handshake read", oe, 1'b1);
    astb = 1'b1; stb = 1'b1; cyc(4);
    chk("R9 wait low after read", wt, 1'b0);
    chk("R10 oe after handshake read", oe, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      rfm[i] = 8'(i * 3 + 1);
      mm[i]  = 8'(i * 3 + 1);
    end

    // mode 0: separate address, separate strobes
    rst_to(1'b1, 1'b1, 1'b0, 3'd0, 3'd0);
    chk("R9 no wait in mode 0", wt, 1'b0);
    sep_w(3'd0, 8'hFB);
    sep_r("R4 page read", 3'd0);
    sep_w(3'd5, 8'hA5);
    sep_r("R3 read back", 3'd5);
    addr = 3'd5; din = 8'hC3; stb = 1'b0; cyc(4); stb = 1'b1; cyc(4);
    dir = 1'b0; cyc(4);
    chk("R10 cs high no drive", oe, 1'b0);
    dir = 1'b1; cyc(4);
    chk("R10 cs high no write", rfm[{pg_m, 3'd5}], mm[{pg_m, 3'd5}]);
    sep_w(3'd0, 8'h00);
    sep_r("R4 page zero read", 3'd5);

    // mode 1: separate address, common strobe
    rst_to(1'b1, 1'b0, 1'b0, 3'd0, 3'd1);
    dir = 1'b1; cyc(2);
    sep_w(3'd0, 8'h01);
    sep_w(3'd2, 8'h3C);
    sep_r("R5 read back", 3'd2);
    sep_r("R4 page read mode 1", 3'd0);

    // mode 2: multiplexed, separate strobes
    rst_to(1'b1, 1'b1, 1'b0, 3'd7, 3'd2);
    mux_w(6'h2A, 8'h77);
    mux_r("R6 mux read back", 6'h2A);
    mux_r("R6 mux read addr 0", 6'h00);

    // mode 3: multiplexed, common strobe
    rst_to(1'b1, 1'b0, 1'b0, 3'd7, 3'd3);
    dir = 1'b1; addr = 3'd0; cyc(2);
    mux_w(6'h3F, 8'h81);
    mux_r("R6 mux common top addr", 6'h3F);
    chk("R2 mode kept after strap change", mode, 3'd3);

    // mode 4: handshake
    rst_to(1'b0, 1'b1, 1'b1, 3'd0, 3'd4);
    e_w(1'b1, 8'h11);
    e_r(1'b1);
    e_w(1'b0, 8'h5A);
    e_r(1'b0);
    cs_n = 1'b1; cyc(2);
    e_w(1'b1, 8'h3F);
    e_w(1'b0, 8'hE7);
    e_r(1'b0);
    chk("R8 cs ignored", mode, 3'd4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      ntot++; nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end
endmodule